// File: doc/BRIEF.md
# Prioritized Exception Cause Recorder

This block sits at the back end of a processor pipeline. In every cycle it gathers all exception requests raised by that cycle's packet: a reset request, an invalid-packet fault, a privilege fault, a misaligned fetch address, the faults of the two load/store slots, and a set of external interrupt lines, each with its own enable bit. It picks one winner and records it. The recorded state is an 8-bit cause code, the PC of the packet that caused the exception, the data address of a faulting memory access, and an exception-active status bit. A one-cycle pulse marks every cycle in which a new exception was recorded.

In general the winner is the request with the numerically lowest cause code. There are two exceptions to that rule:
- Memory slot 1 always goes before memory slot 0.
- A fault raised while an exception is already active is recorded as a double exception.

Vectoring to a handler and returning from it are handled elsewhere. The handler drops the active bit through the clear input. The interface is plain level signalling. The block has no back-pressure: a request is either taken in the cycle it is presented or not at all. The block never stores a request.

Top module: `exc_cause_rec`

## Requirements
- R1: While `rst_ni` is low, and right after it rises, `cause_o`, `elr_o`, `badva_o`, `take_o` and `active_o` are all zero.
- R2: When several requests are present, the one with the lowest cause code wins. The fixed codes are: invalid packet 0x15, privilege 0x1A, misaligned fetch 0x1E. A slot fault's 2-bit kind selects its code: 0 = misaligned load 0x20, 1 = misaligned store 0x21, 2 = translation miss on read 0x70, 3 = translation miss on write 0x71.
- R3: A reset request (`rst_req_i`) wins with code 0x00 over every other request. This holds even while an exception is active, and it cannot be disabled.
- R4: When both memory slots fault in the same cycle, slot 1 is recorded whatever the two codes are, and slot 0 is not taken in that cycle. Slot 0 is arbitrated again only if its fault is still asserted in a later cycle. Nothing is remembered for it.
- R5: Interrupt line n has code 0xC0+n, and the lowest-numbered line wins among the interrupt lines. A line takes part only when its bit in `irq_en_i` is 1.
- R6: A cycle that has a winner is followed by a cycle with `take_o` = 1. In that cycle `cause_o` holds the code, `elr_o` holds the `pc_i` value presented with the request, and `active_o` is 1. After a cycle with no winner, `take_o` is 0.
- R7: `badva_o` is loaded with the winning slot's address only when the recorded code is 0x20, 0x21, 0x70 or 0x71. For every other code it keeps its value.
- R8: Any fault other than a reset request that is raised while `active_o` is 1 and `clear_i` is 0 is recorded with code 0x03. `elr_o` is updated and `badva_o` is kept.
- R9: While `active_o` is 1 and `clear_i` is 0, interrupt lines are not accepted. Without any fault, no exception is taken.
- R10: `clear_i` drops the active bit when no request is taken. A request presented together with `clear_i` is judged as if the block were inactive: it keeps its own code and interrupts are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rst_req_i | input | 1 | Reset exception request |
| bad_pkt_i | input | 1 | Invalid packet fault |
| priv_i | input | 1 | Privilege fault |
| pc_misal_i | input | 1 | Misaligned fetch address fault |
| ls0_fault_i | input | 1 | Load/store slot 0 fault |
| ls0_kind_i | input | 2 | Slot 0 fault kind (see R2) |
| ls0_addr_i | input | VA_W | Slot 0 data address |
| ls1_fault_i | input | 1 | Load/store slot 1 fault |
| ls1_kind_i | input | 2 | Slot 1 fault kind (see R2) |
| ls1_addr_i | input | VA_W | Slot 1 data address |
| irq_i | input | IRQ_N | Interrupt lines |
| irq_en_i | input | IRQ_N | Per-line interrupt enables |
| pc_i | input | PC_W | PC of the current packet |
| clear_i | input | 1 | Drop the exception-active bit |
| take_o | output | 1 | One-cycle pulse: an exception was recorded |
| cause_o | output | 8 | Recorded cause code |
| elr_o | output | PC_W | Recorded packet PC |
| badva_o | output | VA_W | Recorded faulting data address |
| active_o | output | 1 | Exception-active status |

## Verification
The hardest situation to reach from the ports is a slot 0 fault that has lost to slot 1 and then shows up again. It has to come back to an idle block, or else it is turned into a double exception. The stimulus therefore presents both slots with `clear_i` high, and then holds the slot 0 fault alone for one more cycle, again with `clear_i` high. This shows that it is then recorded under its own code and with its own address. A second run drops slot 0 in the follow-up cycle, which shows that no deferred fault is replayed on its own. The double-exception and interrupt-blocking paths are reached by first setting the active bit with `clear_i` low, and then presenting faults or enabled interrupt lines while `clear_i` stays low.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef logic [7:0] cause_t;

  localparam cause_t C_RESET  = 8'h00;
  localparam cause_t C_DOUBLE = 8'h03;
  localparam cause_t C_BADPKT = 8'h15;
  localparam cause_t C_PRIV   = 8'h1A;
  localparam cause_t C_PCMIS  = 8'h1E;
  localparam cause_t C_LDMIS  = 8'h20;
  localparam cause_t C_STMIS  = 8'h21;
  localparam cause_t C_TLBRD  = 8'h70;
  localparam cause_t C_TLBWR  = 8'h71;
  localparam cause_t C_IRQ0   = 8'hC0;

  typedef enum logic [1:0] {
    LS_LDMIS = 2'd0,
    LS_STMIS = 2'd1,
    LS_TLBRD = 2'd2,
    LS_TLBWR = 2'd3
  } ls_kind_e;

  // candidate slots fed to the lowest-code selector
  localparam int SRC_RST  = 0;
  localparam int SRC_PKT  = 1;
  localparam int SRC_PRV  = 2;
  localparam int SRC_PCM  = 3;
  localparam int SRC_SLOT = 4;
  localparam int SRC_IRQ  = 5;
  localparam int NUM_SRC  = 6;

  function automatic cause_t ls_code(input logic [1:0] kind);
    case (ls_kind_e'(kind))
      LS_LDMIS: return C_LDMIS;
      LS_STMIS: return C_STMIS;
      LS_TLBRD: return C_TLBRD;
      default:  return C_TLBWR;
    endcase
  endfunction

  function automatic logic is_data(input cause_t c);
    return (c == C_LDMIS) || (c == C_STMIS) || (c == C_TLBRD) || (c == C_TLBWR);
  endfunction

endpackage

// File: rtl/exc_slot_order.sv
module exc_slot_order
  import exc_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic            s0_vld_i,
  input  logic [1:0]      s0_kind_i,
  input  logic [VA_W-1:0] s0_addr_i,
  input  logic            s1_vld_i,
  input  logic [1:0]      s1_kind_i,
  input  logic [VA_W-1:0] s1_addr_i,
  output logic            vld_o,
  output cause_t          code_o,
  output logic [VA_W-1:0] addr_o
);

  // slot 1 is served first regardless of the codes involved
  always_comb begin
    vld_o = s0_vld_i | s1_vld_i;
    if (s1_vld_i) begin
      code_o = ls_code(s1_kind_i);
      addr_o = s1_addr_i;
    end else begin
      code_o = ls_code(s0_kind_i);
      addr_o = s0_addr_i;
    end
  end

endmodule

// File: rtl/exc_irq_pick.sv
module exc_irq_pick
  import exc_pkg::*;
#(
  parameter int IRQ_N = 8
) (
  input  logic [IRQ_N-1:0] irq_i,
  input  logic [IRQ_N-1:0] en_i,
  output logic             vld_o,
  output cause_t           code_o
);

  localparam int IDX_W = (IRQ_N > 1) ? $clog2(IRQ_N) : 1;

  logic [IRQ_N-1:0] hit;
  logic [IDX_W-1:0] idx;

  for (genvar g = 0; g < IRQ_N; g++) begin : g_line
    assign hit[g] = irq_i[g] & en_i[g];
  end

  // scan from the top so the lowest line number is left standing
  always_comb begin
    idx = '0;
    for (int i = IRQ_N - 1; i >= 0; i--) begin
      if (hit[i]) idx = IDX_W'(i);
    end
  end

  assign vld_o  = |hit;
  assign code_o = C_IRQ0 + cause_t'(idx);

endmodule

// File: rtl/exc_min_sel.sv
module exc_min_sel
  import exc_pkg::*;
#(
  parameter int NUM   = 6,
  parameter int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic [NUM-1:0]      vld_i,
  input  logic [NUM-1:0][7:0] code_i,
  output logic                vld_o,
  output logic [IDX_W-1:0]    idx_o,
  output cause_t              code_o
);

  always_comb begin
    logic              any;
    logic [IDX_W-1:0]  best_idx;
    cause_t            best;
    any      = 1'b0;
    best_idx = '0;
    best     = 8'hFF;
    for (int i = 0; i < NUM; i++) begin
      if (vld_i[i] && (!any || (code_i[i] < best))) begin
        any      = 1'b1;
        best_idx = IDX_W'(i);
        best     = code_i[i];
      end
    end
    vld_o  = any;
    idx_o  = best_idx;
    code_o = best;
  end

endmodule

// File: rtl/exc_cause_rec.sv
module exc_cause_rec
  import exc_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int VA_W  = 32,
  parameter int IRQ_N = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rst_req_i,
  input  logic             bad_pkt_i,
  input  logic             priv_i,
  input  logic             pc_misal_i,
  input  logic             ls0_fault_i,
  input  logic [1:0]       ls0_kind_i,
  input  logic [VA_W-1:0]  ls0_addr_i,
  input  logic             ls1_fault_i,
  input  logic [1:0]       ls1_kind_i,
  input  logic [VA_W-1:0]  ls1_addr_i,
  input  logic [IRQ_N-1:0] irq_i,
  input  logic [IRQ_N-1:0] irq_en_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             clear_i,
  output logic             take_o,
  output logic [7:0]       cause_o,
  output logic [PC_W-1:0]  elr_o,
  output logic [VA_W-1:0]  badva_o,
  output logic             active_o
);

  localparam int IDX_W = $clog2(NUM_SRC);

  logic                     act_q, take_q;
  cause_t                   cause_q;
  logic [PC_W-1:0]          elr_q;
  logic [VA_W-1:0]          bad_q;

  logic                     act_eff;
  logic                     slot_vld, irq_vld;
  cause_t                   slot_code, irq_code;
  logic [VA_W-1:0]          slot_addr;
  logic [NUM_SRC-1:0]       cand_vld;
  logic [NUM_SRC-1:0][7:0]  cand_code;
  logic                     win_vld;
  logic [IDX_W-1:0]         win_idx;
  cause_t                   win_code, fin_code;

  // a clear in the same cycle makes new requests see an idle block
  assign act_eff = act_q & ~clear_i;

  exc_slot_order #(.VA_W(VA_W)) u_slot (
    .s0_vld_i (ls0_fault_i),
    .s0_kind_i(ls0_kind_i),
    .s0_addr_i(ls0_addr_i),
    .s1_vld_i (ls1_fault_i),
    .s1_kind_i(ls1_kind_i),
    .s1_addr_i(ls1_addr_i),
    .vld_o    (slot_vld),
    .code_o   (slot_code),
    .addr_o   (slot_addr)
  );

  exc_irq_pick #(.IRQ_N(IRQ_N)) u_irq (
    .irq_i (irq_i),
    .en_i  (irq_en_i),
    .vld_o (irq_vld),
    .code_o(irq_code)
  );

  always_comb begin
    cand_vld             = '0;
    cand_code            = '0;
    cand_vld[SRC_RST]    = rst_req_i;
    cand_code[SRC_RST]   = C_RESET;
    cand_vld[SRC_PKT]    = bad_pkt_i;
    cand_code[SRC_PKT]   = C_BADPKT;
    cand_vld[SRC_PRV]    = priv_i;
    cand_code[SRC_PRV]   = C_PRIV;
    cand_vld[SRC_PCM]    = pc_misal_i;
    cand_code[SRC_PCM]   = C_PCMIS;
    cand_vld[SRC_SLOT]   = slot_vld;
    cand_code[SRC_SLOT]  = slot_code;
    cand_vld[SRC_IRQ]    = irq_vld & ~act_eff;
    cand_code[SRC_IRQ]   = irq_code;
  end

  exc_min_sel #(.NUM(NUM_SRC), .IDX_W(IDX_W)) u_min (
    .vld_i (cand_vld),
    .code_i(cand_code),
    .vld_o (win_vld),
    .idx_o (win_idx),
    .code_o(win_code)
  );

  // nested non-reset faults collapse into the double-exception code
  assign fin_code = (act_eff && (win_idx != IDX_W'(SRC_RST))) ? C_DOUBLE : win_code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      take_q  <= 1'b0;
      cause_q <= C_RESET;
      elr_q   <= '0;
      bad_q   <= '0;
    end else begin
      take_q <= win_vld;
      if (win_vld) begin
        act_q   <= 1'b1;
        cause_q <= fin_code;
        elr_q   <= pc_i;
        if (is_data(fin_code)) bad_q <= slot_addr;
      end else if (clear_i) begin
        act_q <= 1'b0;
      end
    end
  end

  assign take_o   = take_q;
  assign cause_o  = cause_q;
  assign elr_o    = elr_q;
  assign badva_o  = bad_q;
  assign active_o = act_q;

endmodule

// File: rtl/exc_cause_rec_chk.sv
module exc_cause_rec_chk #(
  parameter int VA_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            rst_req_i,
  input logic            bad_pkt_i,
  input logic            priv_i,
  input logic            pc_misal_i,
  input logic            ls0_fault_i,
  input logic            ls1_fault_i,
  input logic            clear_i,
  input logic            take_o,
  input logic [7:0]      cause_o,
  input logic [VA_W-1:0] badva_o,
  input logic            active_o
);

  logic any_fault;
  assign any_fault = bad_pkt_i | priv_i | pc_misal_i | ls0_fault_i | ls1_fault_i;

  // R6
  take_sets_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> active_o);

  // R3
  reset_req_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> (take_o && cause_o == 8'h00));

  // R8
  nested_is_double_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !clear_i && !rst_req_i && any_fault) |=> (take_o && cause_o == 8'h03));

  // R9
  irq_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !clear_i && !rst_req_i && !any_fault) |=> !take_o);

  // R7
  badva_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> $stable(badva_o));

endmodule

bind exc_cause_rec exc_cause_rec_chk #(.VA_W(VA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rst_req_i  (rst_req_i),
  .bad_pkt_i  (bad_pkt_i),
  .priv_i     (priv_i),
  .pc_misal_i (pc_misal_i),
  .ls0_fault_i(ls0_fault_i),
  .ls1_fault_i(ls1_fault_i),
  .clear_i    (clear_i),
  .take_o     (take_o),
  .cause_o    (cause_o),
  .badva_o    (badva_o),
  .active_o   (active_o)
);

// File: tb/exc_cause_rec_bench.sv
module exc_cause_rec_bench;

  localparam int PC_W = 32;
  localparam int VA_W = 32;
  localparam int IRQ_N = 8;

  typedef struct packed {
    logic       rst;
    logic       pkt;
    logic       prv;
    logic       pcm;
    logic       s0v;
    logic [1:0] s0k;
    logic       s1v;
    logic [1:0] s1k;
    logic [7:0] irq;
    logic [7:0] en;
    logic       take;
    logic [7:0] cause;
    logic [1:0] bad;   // 0 keep, 1 slot0 address, 2 slot1 address
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,2'd0,8'h00,8'h00,1'b0,8'h00,2'd0},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,1'b0,2'd0,8'h00,8'h00,1'b1,8'h20,2'd1},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,1'b1,2'd3,8'h00,8'h00,1'b1,8'h71,2'd2},
    '{1'b0,1'b1,1'b0,1'b1,1'b0,2'd0,1'b0,2'd0,8'h01,8'h01,1'b1,8'h15,2'd0},
    '{1'b0,1'b0,1'b1,1'b0,1'b1,2'd1,1'b0,2'd0,8'h00,8'h00,1'b1,8'h1A,2'd0},
    '{1'b1,1'b1,1'b1,1'b1,1'b1,2'd2,1'b1,2'd3,8'hFF,8'hFF,1'b1,8'h00,2'd0},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,2'd0,8'hA4,8'hFF,1'b1,8'hC2,2'd0},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,2'd0,8'h05,8'hFE,1'b1,8'hC2,2'd0},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,2'd0,8'hFF,8'h00,1'b0,8'h00,2'd0},
    '{1'b0,1'b0,1'b0,1'b1,1'b1,2'd2,1'b0,2'd0,8'h00,8'h00,1'b1,8'h1E,2'd0},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,1'b1,2'd0,8'h00,8'h00,1'b1,8'h20,2'd2},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,2'd0,8'h80,8'h80,1'b1,8'hC7,2'd0},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,2'd3,1'b0,2'd0,8'h10,8'h10,1'b1,8'h71,2'd1},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,2'd2,1'b1,2'd1,8'h00,8'h00,1'b1,8'h21,2'd2}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rst_req, bad_pkt, priv, pc_misal, ls0_f, ls1_f, clear;
  logic [1:0]       ls0_k, ls1_k;
  logic [VA_W-1:0]  ls0_a, ls1_a;
  logic [IRQ_N-1:0] irq, irq_en;
  logic [PC_W-1:0]  pc;
  logic             take, active;
  logic [7:0]       cause;
  logic [PC_W-1:0]  elr;
  logic [VA_W-1:0]  badva;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  logic [VA_W-1:0] exp_bad;
  logic [7:0]      last_cause;

  always #10 clk = ~clk;

  exc_cause_rec #(.PC_W(PC_W), .VA_W(VA_W), .IRQ_N(IRQ_N)) u_exc_cause_rec (
    .clk_i(clk), .rst_ni(rst_n), .rst_req_i(rst_req), .bad_pkt_i(bad_pkt),
    .priv_i(priv), .pc_misal_i(pc_misal),
    .ls0_fault_i(ls0_f), .ls0_kind_i(ls0_k), .ls0_addr_i(ls0_a),
    .ls1_fault_i(ls1_f), .ls1_kind_i(ls1_k), .ls1_addr_i(ls1_a),
    .irq_i(irq), .irq_en_i(irq_en), .pc_i(pc), .clear_i(clear),
    .take_o(take), .cause_o(cause), .elr_o(elr), .badva_o(badva), .active_o(active)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic idle();
    rst_req = 0; bad_pkt = 0; priv = 0; pc_misal = 0; clear = 0;
    ls0_f = 0; ls0_k = 0; ls0_a = '0; ls1_f = 0; ls1_k = 0; ls1_a = '0;
    irq = '0; irq_en = '0; pc = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired, requirement R6 flow stalled: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(take, 0, "R1 take in reset");
    chk(active, 0, "R1 active in reset");
    chk(cause, 0, "R1 cause in reset");
    chk(elr, 0, "R1 elr in reset");
    chk(badva, 0, "R1 badva in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(active, 0, "R1 active after reset");
    exp_bad = '0;

    // table walk, each row with clear high so the block looks idle
    for (int i = 0; i < NV; i++) begin
      idle();
      clear    = 1;
      rst_req  = VECS[i].rst;
      bad_pkt  = VECS[i].pkt;
      priv     = VECS[i].prv;
      pc_misal = VECS[i].pcm;
      ls0_f    = VECS[i].s0v;
      ls0_k    = VECS[i].s0k;
      ls0_a    = 32'h1000_0000 | i;
      ls1_f    = VECS[i].s1v;
      ls1_k    = VECS[i].s1k;
      ls1_a    = 32'h2000_0000 | i;
      irq      = VECS[i].irq;
      irq_en   = VECS[i].en;
      pc       = 32'h4000_0000 + 32'(i * 16);
      if (VECS[i].bad == 2'd1) exp_bad = 32'h1000_0000 | i;
      if (VECS[i].bad == 2'd2) exp_bad = 32'h2000_0000 | i;
      @(negedge clk);
      chk(take, VECS[i].take, $sformatf("R6 take row %0d", i));
      chk(active, VECS[i].take, $sformatf("R10 active row %0d", i));
      if (VECS[i].take) begin
        chk(cause, VECS[i].cause, $sformatf("R2 R3 R4 R5 cause row %0d", i));
        chk(elr, 32'h4000_0000 + 32'(i * 16), $sformatf("R6 elr row %0d", i));
      end
      chk(badva, exp_bad, $sformatf("R7 badva row %0d", i));
    end

    // R6: pulse lasts one cycle, active stays
    idle(); ls0_f = 1; ls0_k = 2'd1; ls0_a = 32'hAAAA_0000; clear = 1; pc = 32'h100;
    @(negedge clk);
    chk(cause, 8'h21, "R6 setup cause");
    exp_bad = 32'hAAAA_0000;
    idle();
    @(negedge clk);
    chk(take, 0, "R6 pulse ends");
    chk(active, 1, "R6 active held");

    // R8: nested faults become double exceptions
    idle(); priv = 1; pc = 32'h200;
    @(negedge clk);
    chk(cause, 8'h03, "R8 nested privilege");
    chk(elr, 32'h200, "R8 elr updated");
    idle(); ls1_f = 1; ls1_k = 2'd2; ls1_a = 32'hBBBB_0000; pc = 32'h204;
    @(negedge clk);
    chk(cause, 8'h03, "R8 nested slot fault");
    chk(badva, exp_bad, "R8 badva kept");

    // R9: interrupts ignored while active
    idle(); irq = 8'h01; irq_en = 8'hFF; pc = 32'h300;
    @(negedge clk);
    chk(take, 0, "R9 irq blocked take");
    chk(cause, 8'h03, "R9 cause unchanged");
    chk(elr, 32'h204, "R9 elr unchanged");

    // R3: reset request wins while active
    idle(); rst_req = 1; priv = 1; pc = 32'h400;
    @(negedge clk);
    chk(cause, 8'h00, "R3 reset while active");

    // R10: clear drops active, clear with request takes own code
    idle(); clear = 1;
    @(negedge clk);
    chk(active, 0, "R10 clear drops active");
    chk(take, 0, "R10 no take on clear");
    idle(); priv = 1; pc = 32'h500;
    @(negedge clk);
    chk(cause, 8'h1A, "R10 fresh fault own code");
    idle(); clear = 1; irq = 8'h08; irq_en = 8'h08; pc = 32'h504;
    @(negedge clk);
    chk(cause, 8'hC3, "R10 irq with clear accepted");
    chk(active, 1, "R10 active after take with clear");

    // R4: slot 0 deferred, retaken only while still asserted
    idle(); clear = 1; ls0_f = 1; ls0_k = 2'd1; ls0_a = 32'hC000_0000;
    ls1_f = 1; ls1_k = 2'd2; ls1_a = 32'hD000_0000; pc = 32'h600;
    @(negedge clk);
    chk(cause, 8'h70, "R4 slot1 first");
    chk(badva, 32'hD000_0000, "R4 slot1 address");
    idle(); clear = 1; ls0_f = 1; ls0_k = 2'd1; ls0_a = 32'hC000_0000; pc = 32'h604;
    @(negedge clk);
    chk(cause, 8'h21, "R4 slot0 follow-up");
    chk(badva, 32'hC000_0000, "R4 slot0 address");
    chk(elr, 32'h604, "R4 slot0 elr");
    idle(); clear = 1; ls0_f = 1; ls0_k = 2'd0; ls0_a = 32'hE000_0000;
    ls1_f = 1; ls1_k = 2'd3; ls1_a = 32'hF000_0000;
    @(negedge clk);
    chk(cause, 8'h71, "R4 slot1 beats lower slot0 code");
    idle(); clear = 1;
    @(negedge clk);
    chk(take, 0, "R4 dropped slot0 not replayed");
    chk(badva, 32'hF000_0000, "R4 badva after drop");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule